// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This block turns a saved operation class and two saved operands into the four integer condition flags of a 32-bit processor: negative, zero, overflow and carry. It also keeps the extend flag. A front end that does not want to compute flags on every instruction hands over the class, the source operand and the result (the "destination") in one cycle. The block derives the flags from those values and holds the packed flag word and the extend bit in registers until the next request. Two further classes take raw operands instead of a result. They perform one step of a multi-word add or subtract: the current extend bit is used as the carry-in, and the computed result is returned on a data output.

Control is a two-state machine. In `ST_IDLE` nothing is pending. A request with `in_valid` high is captured on a clock edge, and the machine moves to `ST_EVAL` (transition *accept*). In `ST_EVAL` the flag registers are written on the next edge. The machine then returns to `ST_IDLE` (transition *retire*), or stays in `ST_EVAL` if a new request arrived (transition *chain*). The state a request sees therefore already includes every earlier request, so back-to-back multi-word steps use the extend bit of the step before.

Top module: `ccf_unit`

## Requirements
- R1: After reset `out_flags` is 0, `out_x` is 0, `out_err` is 0 and `out_done` is 0.
- R2: A request captured on clock edge k updates `out_flags`, `out_x`, `out_err` and `out_res`, and pulses `out_done` high, right after edge k+1. A request may be given on every cycle.
- R3: The flag word places carry in bit 0, overflow in bit 1, zero in bit 2 and negative in bit 3. Class 0 (flags already valid) loads `in_dst[3:0]` into the flag word unchanged.
- R4: Class 1 (logic) sets N from `in_dst[31]` and Z when `in_dst` is zero, and clears C and V.
- R5: Class 2 (add) sets C when `in_dst < in_src` (unsigned), and V when the first operand `in_dst - in_src` and `in_src` share a sign that `in_dst` lacks. Class 6 (add with extend) uses `in_dst <= in_src` for C and `in_dst - in_src - 1` as the first operand.
- R6: Class 3 (subtract) rebuilds the first operand a = `in_dst + in_src`. C is a borrow (a < `in_src`, unsigned). V is set when a and `in_src` differ in sign and `in_dst` differs in sign from a. Class 7 (subtract with extend) uses a = `in_dst + in_src + 1` and C when a <= `in_src`.
- R7: Classes 4 and 5 apply the class 3 rule to the low 8 and low 16 bits, taking N, Z, C and V at that width.
- R8: Class 8 (shift) sets N and Z from `in_dst`, sets C when `in_src` (the saved carry-out) is nonzero, and clears V.
- R9: For classes 6, 7, 9 and 10 the new Z is the computed Z ANDed with the previous Z, so those classes can clear Z but never set it.
- R10: Classes 2, 3, 6, 7, 8, 9 and 10 copy the new C into `out_x`. Classes 0, 1, 4 and 5 leave `out_x` unchanged.
- R11: Class 9 returns `in_dst + in_src + X` on `out_res` and class 10 returns `in_dst - in_src - X`, using the current X. When X was set, their flags follow class 6 or 7, and class 2 or 3 otherwise. All other classes return `in_dst` on `out_res`.
- R12: Class codes 11 to 15 raise `out_err` for that request and leave `out_flags` and `out_x` unchanged. A valid class clears `out_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, captured on the clock edge |
| in_op | input | 4 | Operation class code |
| in_src | input | 32 | Saved source operand, or second operand for classes 9 and 10 |
| in_dst | input | 32 | Saved result, or first operand for classes 9 and 10 |
| out_done | output | 1 | One-cycle pulse when a request has been evaluated |
| out_err | output | 1 | Last request used an unknown class code |
| out_flags | output | 4 | Flag word {N, Z, V, C} |
| out_x | output | 1 | Extend flag |
| out_res | output | 32 | Multi-word step result, or the saved result |

## Verification
The flag word and the extend bit are the only state that lives longer than one request, and both appear directly on the ports. A wrong value shows up at the next `out_done` and is carried into every later request. An extend bit that is wrong after one multi-word step shows up one request later in `out_res` of the next step, and a lost sticky zero shows up as a Z that rises partway through a chain. The bench keeps its own copy of flags and extend bit, and compares all five outputs after every request. Random requests that include unknown codes are mixed with directed overflow, borrow and chained cases.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    typedef enum logic [3:0] {
        OPC_PASS  = 4'd0,
        OPC_LOGIC = 4'd1,
        OPC_ADD   = 4'd2,
        OPC_SUB   = 4'd3,
        OPC_CMP8  = 4'd4,
        OPC_CMP16 = 4'd5,
        OPC_ADDX  = 4'd6,
        OPC_SUBX  = 4'd7,
        OPC_SHIFT = 4'd8,
        OPC_CHADD = 4'd9,
        OPC_CHSUB = 4'd10
    } opc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } st_e;

    localparam int FL_C = 0;
    localparam int FL_V = 1;
    localparam int FL_Z = 2;
    localparam int FL_N = 3;

    function automatic logic [3:0] pack_flags(input logic n, input logic z,
                                              input logic v, input logic c);
        return {n, z, v, c};
    endfunction

endpackage

// File: rtl/ccf_subw.sv
// Subtract/compare flag rule at one operand width.
module ccf_subw #(
    parameter int W = 32
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    output logic         n_o,
    output logic         z_o,
    output logic         c_o,
    output logic         v_o
);
    logic [W-1:0] first_op;
    logic [W-1:0] ov_vec;

    always_comb begin
        first_op = dst_i + src_i;
        ov_vec   = (first_op ^ dst_i) & (first_op ^ src_i);
        n_o      = dst_i[W-1];
        z_o      = (dst_i == '0);
        c_o      = (first_op < src_i);
        v_o      = ov_vec[W-1];
    end
endmodule

// File: rtl/ccf_chain.sv
// One step of a multi-word add or subtract with the extend bit as carry.
module ccf_chain #(
    parameter int W = 32
) (
    input  logic         is_sub_i,
    input  logic         cin_i,
    input  logic [W-1:0] op1_i,
    input  logic [W-1:0] op2_i,
    output logic [W-1:0] res_o
);
    logic [W-1:0] cin_vec;

    always_comb begin
        cin_vec = {{(W-1){1'b0}}, cin_i};
        res_o   = is_sub_i ? (op1_i - op2_i - cin_vec) : (op1_i + op2_i + cin_vec);
    end
endmodule

// File: rtl/ccf_eval.sv
// Combinational flag derivation from class, source and result.
module ccf_eval
    import ccf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   cls_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    input  logic [3:0]   prev_flags_i,
    input  logic         prev_x_i,
    output logic [3:0]   flags_o,
    output logic         x_o,
    output logic         err_o
);
    localparam int NSUB = 3;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [NSUB-1:0] sn, sz, sc, sv;

    // widths W, W/2, W/4: full subtract, word compare, byte compare
    for (genvar g = 0; g < NSUB; g++) begin : g_sub
        localparam int GW = W >> g;
        ccf_subw #(.W(GW)) u_subw (
            .src_i (src_i[GW-1:0]),
            .dst_i (dst_i[GW-1:0]),
            .n_o   (sn[g]),
            .z_o   (sz[g]),
            .c_o   (sc[g]),
            .v_o   (sv[g])
        );
    end

    logic [W-1:0] add_back, addx_back, subx_fwd;
    logic [W-1:0] add_ov, addx_ov, subx_ov;
    logic         rn, rz, pz;

    always_comb begin
        rn        = dst_i[W-1];
        rz        = (dst_i == '0);
        pz        = prev_flags_i[FL_Z];
        add_back  = dst_i - src_i;
        addx_back = dst_i - src_i - ONE;
        subx_fwd  = dst_i + src_i + ONE;
        add_ov    = (src_i ^ dst_i) & ~(add_back ^ src_i);
        addx_ov   = (src_i ^ dst_i) & ~(addx_back ^ src_i);
        subx_ov   = (subx_fwd ^ dst_i) & (subx_fwd ^ src_i);
        flags_o   = prev_flags_i;
        x_o       = prev_x_i;
        err_o     = 1'b0;
        case (cls_i)
            OPC_PASS:  flags_o = dst_i[3:0];
            OPC_LOGIC: flags_o = pack_flags(rn, rz, 1'b0, 1'b0);
            OPC_ADD: begin
                flags_o = pack_flags(rn, rz, add_ov[W-1], dst_i < src_i);
                x_o     = flags_o[FL_C];
            end
            OPC_SUB: begin
                flags_o = pack_flags(sn[0], sz[0], sv[0], sc[0]);
                x_o     = flags_o[FL_C];
            end
            OPC_CMP16: flags_o = pack_flags(sn[1], sz[1], sv[1], sc[1]);
            OPC_CMP8:  flags_o = pack_flags(sn[2], sz[2], sv[2], sc[2]);
            OPC_ADDX: begin
                flags_o = pack_flags(rn, rz & pz, addx_ov[W-1], dst_i <= src_i);
                x_o     = flags_o[FL_C];
            end
            OPC_SUBX: begin
                flags_o = pack_flags(rn, rz & pz, subx_ov[W-1], subx_fwd <= src_i);
                x_o     = flags_o[FL_C];
            end
            OPC_SHIFT: begin
                flags_o = pack_flags(rn, rz, 1'b0, src_i != '0);
                x_o     = flags_o[FL_C];
            end
            default:   err_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/ccf_unit.sv
module ccf_unit
    import ccf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   in_op,
    input  logic [W-1:0] in_src,
    input  logic [W-1:0] in_dst,
    output logic         out_done,
    output logic         out_err,
    output logic [3:0]   out_flags,
    output logic         out_x,
    output logic [W-1:0] out_res
);
    st_e          state_q, state_nx;
    logic [3:0]   op_q, done_op_q;
    logic [W-1:0] src_q, dst_q;
    logic [3:0]   flags_q;
    logic         x_q, err_q, done_q;
    logic [W-1:0] res_q;

    logic         is_chain, chain_sub;
    logic [W-1:0] chain_res, ev_dst;
    logic [3:0]   ev_cls, ev_flags, flags_nx;
    logic         ev_x, ev_err;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: state_nx = in_valid ? ST_EVAL : ST_IDLE;  // accept
            ST_EVAL: state_nx = in_valid ? ST_EVAL : ST_IDLE;  // chain / retire
        endcase
    end

    // ---------------- request capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OPC_PASS;
            src_q <= '0;
            dst_q <= '0;
        end else if (in_valid) begin
            op_q  <= in_op;
            src_q <= in_src;
            dst_q <= in_dst;
        end
    end

    // ---------------- datapath ----------------
    always_comb begin
        is_chain  = (op_q == OPC_CHADD) || (op_q == OPC_CHSUB);
        chain_sub = (op_q == OPC_CHSUB);
    end

    ccf_chain #(.W(W)) u_chain (
        .is_sub_i (chain_sub),
        .cin_i    (x_q),
        .op1_i    (dst_q),
        .op2_i    (src_q),
        .res_o    (chain_res)
    );

    always_comb begin
        ev_dst = is_chain ? chain_res : dst_q;
        if (op_q == OPC_CHADD)      ev_cls = x_q ? OPC_ADDX : OPC_ADD;
        else if (op_q == OPC_CHSUB) ev_cls = x_q ? OPC_SUBX : OPC_SUB;
        else                        ev_cls = op_q;
    end

    ccf_eval #(.W(W)) u_eval (
        .cls_i        (ev_cls),
        .src_i        (src_q),
        .dst_i        (ev_dst),
        .prev_flags_i (flags_q),
        .prev_x_i     (x_q),
        .flags_o      (ev_flags),
        .x_o          (ev_x),
        .err_o        (ev_err)
    );

    always_comb begin
        flags_nx = ev_flags;
        if (is_chain) flags_nx[FL_Z] = ev_flags[FL_Z] & flags_q[FL_Z];
    end

    // ---------------- output registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q   <= '0;
            x_q       <= 1'b0;
            err_q     <= 1'b0;
            done_q    <= 1'b0;
            res_q     <= '0;
            done_op_q <= OPC_PASS;
        end else begin
            done_q <= (state_q == ST_EVAL);
            if (state_q == ST_EVAL) begin
                err_q     <= ev_err;
                done_op_q <= op_q;
                res_q     <= ev_dst;
                if (!ev_err) begin
                    flags_q <= flags_nx;
                    x_q     <= ev_x;
                end
            end
        end
    end

    assign out_done  = done_q;
    assign out_err   = err_q;
    assign out_flags = flags_q;
    assign out_x     = x_q;
    assign out_res   = res_q;

    // ---------------- assertions ----------------
    AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_err) |-> (out_flags == $past(out_flags) && out_x == $past(out_x))); // R12

    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && !out_err && done_op_q == OPC_LOGIC) |-> (out_flags[FL_C] == 1'b0 && out_flags[FL_V] == 1'b0)); // R4

    AST_STICKY_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && !out_err && !$past(out_flags[FL_Z]) &&
         (done_op_q == OPC_ADDX || done_op_q == OPC_SUBX || done_op_q == OPC_CHADD || done_op_q == OPC_CHSUB))
        |-> !out_flags[FL_Z]); // R9

    AST_X_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && (done_op_q == OPC_PASS || done_op_q == OPC_LOGIC || done_op_q == OPC_CMP8 || done_op_q == OPC_CMP16))
        |-> out_x == $past(out_x)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_done) |-> $past(state_q == ST_EVAL)); // R2
endmodule

// File: tb/ccf_unit_tb.sv
`timescale 1ns/1ps
module ccf_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [31:0] in_src = '0, in_dst = '0;
    logic        out_done, out_err, out_x;
    logic [3:0]  out_flags;
    logic [31:0] out_res;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [3:0] m_flags = '0;
    logic       m_x = 1'b0;

    always #4 clk = ~clk;

    ccf_unit #(.W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_src(in_src), .in_dst(in_dst), .out_done(out_done), .out_err(out_err),
        .out_flags(out_flags), .out_x(out_x), .out_res(out_res)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // width-limited subtract rule: a = d + s, result d = a - s
    function automatic logic [3:0] sub_rule(input int w, input logic [31:0] s, input logic [31:0] d);
        logic [31:0] m, sm, dm, a, ov;
        m  = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        sm = s & m; dm = d & m; a = (dm + sm) & m;
        ov = ((a ^ sm) & (a ^ dm)) >> (w - 1);
        return {dm[w-1], dm == 32'h0, ov[0], a < sm};
    endfunction

    function automatic logic sgn_ovf_add(input logic [31:0] a, input logic [31:0] b, input logic [31:0] r);
        return (a[31] == b[31]) && (r[31] != a[31]);
    endfunction

    // Model: returns {err, x, flags} and result, updates model state.
    task automatic model(input logic [3:0] op, input logic [31:0] s, input logic [31:0] d,
                         output logic [3:0] ef, output logic ex, output logic ee, output logic [31:0] er);
        logic [32:0] wide;
        logic [31:0] a;
        ef = m_flags; ex = m_x; ee = 1'b0; er = d;
        case (op)
            4'd0: ef = d[3:0];
            4'd1: ef = {d[31], d == 0, 2'b00};
            4'd2: begin
                a = d - s; wide = {1'b0, a} + {1'b0, s};
                ef = {d[31], d == 0, sgn_ovf_add(a, s, d), wide[32]}; ex = ef[0];
            end
            4'd3: begin ef = sub_rule(32, s, d); ex = ef[0]; end
            4'd4: ef = sub_rule(8, s, d);
            4'd5: ef = sub_rule(16, s, d);
            4'd6: begin
                a = d - s - 32'd1; wide = {1'b0, a} + {1'b0, s} + 33'd1;
                ef = {d[31], (d == 0) & m_flags[2], sgn_ovf_add(a, s, d), wide[32]}; ex = ef[0];
            end
            4'd7: begin
                a = d + s + 32'd1; wide = {1'b0, a} - {1'b0, s} - 33'd1;
                ef = {d[31], (d == 0) & m_flags[2], ((a[31] != s[31]) && (d[31] != a[31])), wide[32]}; ex = ef[0];
            end
            4'd8: begin ef = {d[31], d == 0, 1'b0, s != 0}; ex = ef[0]; end
            4'd9: begin
                wide = {1'b0, d} + {1'b0, s} + {32'd0, m_x}; er = wide[31:0];
                ef = {er[31], (er == 0) & m_flags[2], sgn_ovf_add(d, s, er), wide[32]}; ex = ef[0];
            end
            4'd10: begin
                wide = {1'b0, d} - {1'b0, s} - {32'd0, m_x}; er = wide[31:0];
                ef = {er[31], (er == 0) & m_flags[2], ((d[31] != s[31]) && (er[31] != d[31])), wide[32]}; ex = ef[0];
            end
            default: ee = 1'b1;
        endcase
        m_flags = ef; m_x = ex;
    endtask

    task automatic compare(input string req, input logic [3:0] ef, input logic ex,
                           input logic ee, input logic [31:0] er);
        chk({req, " done"}, {31'd0, out_done}, 32'd1);
        chk({req, " flags"}, {28'd0, out_flags}, {28'd0, ef});
        chk({req, " x"}, {31'd0, out_x}, {31'd0, ex});
        chk({req, " err"}, {31'd0, out_err}, {31'd0, ee});
        chk({req, " res"}, out_res, er);
    endtask

    task automatic run(input string req, input logic [3:0] op, input logic [31:0] s, input logic [31:0] d);
        logic [3:0] ef; logic ex, ee; logic [31:0] er;
        in_valid = 1'b1; in_op = op; in_src = s; in_dst = d;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        model(op, s, d, ef, ex, ee, er);
        compare(req, ef, ex, ee, er);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 flags", {28'd0, out_flags}, 32'd0);
        chk("R1 x", {31'd0, out_x}, 32'd0);
        chk("R1 err", {31'd0, out_err}, 32'd0);
        chk("R1 done", {31'd0, out_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after release", {31'd0, out_done}, 32'd0);

        run("R3 pass", 4'd0, 32'h0, 32'h0000_000A);
        run("R4 logic zero", 4'd1, 32'h5, 32'h0);
        run("R4 logic negative", 4'd1, 32'h0, 32'h8000_0001);
        run("R5 add overflow", 4'd2, 32'h1, 32'h8000_0000);
        run("R5 add carry", 4'd2, 32'hFFFF_FFFF, 32'h0000_0004);
        run("R5 addx carry on equal", 4'd6, 32'h10, 32'h10);
        run("R6 sub borrow", 4'd3, 32'h5, 32'hFFFF_FFFE);
        run("R6 subx", 4'd7, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        run("R7 cmp8 zero", 4'd4, 32'hAB12, 32'hFF00);
        run("R7 cmp16 overflow", 4'd5, 32'h0001, 32'h7FFF);
        run("R8 shift carry", 4'd8, 32'h1, 32'h0);
        run("R8 shift no carry", 4'd8, 32'h0, 32'h8000_0000);
        run("R12 unknown code", 4'd13, 32'h1, 32'h2);
        run("R12 err clears", 4'd1, 32'h0, 32'h0);
        // R9 / R11 multi-word add: set Z, clear X, then chain
        run("R10 clear x", 4'd2, 32'h0, 32'h0);
        run("R11 chain add low", 4'd9, 32'h1, 32'hFFFF_FFFF);
        run("R9 chain add high sticky", 4'd9, 32'h0, 32'h0);
        run("R9 addx cannot set z", 4'd6, 32'h3, 32'h0);
        run("R11 chain sub low", 4'd10, 32'h2, 32'h1);
        run("R11 chain sub high", 4'd10, 32'h0, 32'h1);
        run("R10 cmp keeps x", 4'd5, 32'h9, 32'h3);

        // R2 back-to-back requests
        begin
            logic [3:0] ef; logic ex, ee; logic [31:0] er;
            in_valid = 1'b1; in_op = 4'd9; in_src = 32'hFFFF_FFFF; in_dst = 32'h1;
            @(posedge clk); @(negedge clk);
            in_op = 4'd9; in_src = 32'h0; in_dst = 32'h0;
            @(posedge clk); @(negedge clk);
            in_valid = 1'b0;
            model(4'd9, 32'hFFFF_FFFF, 32'h1, ef, ex, ee, er);
            compare("R2 back-to-back first", ef, ex, ee, er);
            @(posedge clk); @(negedge clk);
            model(4'd9, 32'h0, 32'h0, ef, ex, ee, er);
            compare("R2 back-to-back second", ef, ex, ee, er);
            @(posedge clk); @(negedge clk);
            chk("R2 done drops", {31'd0, out_done}, 32'd0);
        end

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] op; logic [31:0] s, d;
            op = 4'($urandom_range(0, 15));
            s = $urandom; d = $urandom;
            if ($urandom_range(0, 3) == 0) d = 32'h0;
            if ($urandom_range(0, 3) == 0) s = 32'($urandom_range(0, 3));
            run("R3-mix random", op, s, d);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R2 actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule